// File: doc/BRIEF.md
# Flash Range Erase/Program Sequencer

This block turns one request of the form "erase or program this byte range" into a chain of single-unit flash operations. The chain runs in hardware, so software does not have to loop over the range. An erase is split into whole 8 KB sector erases. A program is split into 8-byte double-word writes. Each unit is handed to a simple operation port as a one-cycle start pulse. The next unit is issued only after that port returns a completion pulse with a success bit. A running current address, compared against start plus length, decides whether another unit follows or the request is finished.

The requester sees three things:

- a status code that reads idle, writing or erasing;
- a busy flag;
- two sticky error flags: one for a rejected misaligned start, one for a unit that reported failure.

A one-cycle completion interrupt is raised when a request ends, but only while interrupts are enabled. For program requests, a data pointer travels with the address and moves forward 8 bytes per unit, so the operation port knows where to fetch each double word. Requests that arrive while a chain is running are dropped without effect.

Top module: `flash_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `state` reads 0, and `busy`, `op_start`, `irq_done`, `err_align` and `err_fail` are all 0.
- R2: An erase request (`req_kind`=0) whose `req_addr` is a multiple of 8192 issues one unit per sector. The units go to `op_addr` = start, start+8192, and so on, for as long as that address is below start+`req_len`, so a partial last sector is still erased. Every one of these units has `op_kind`=0.
- R3: A program request (`req_kind`=1) whose `req_addr` is a multiple of 8 issues units 8 bytes apart, with `op_kind`=1. `op_ptr` starts at `req_ptr` and advances by 8 with each unit.
- R4: At most one unit is outstanding. The first `op_start` pulse, one cycle long, comes in the cycle after the request is accepted. Each later pulse comes in the cycle after an `op_done` with `op_ok`=1, and never twice in a row.
- R5: `state` encodes 0 = idle, 1 = writing (program chain) and 2 = erasing (erase chain). `busy` is 1 exactly when `state` is not 0.
- R6: After `op_done` with `op_ok`=1 for the last unit, `state` returns to 0 in the next cycle. In that same next cycle `irq_done` pulses for one cycle, if `irq_en` was 1.
- R7: An `op_done` with `op_ok`=0 ends the chain. In the next cycle `err_fail` is set, `state` is 0 and no further unit is started. `irq_done` pulses if enabled.
- R8: An idle request whose start address is not a multiple of the unit size sets `err_align`. It starts no unit, raises no interrupt and leaves `state` at 0. Alignment is judged before length, so a misaligned zero-length request is also rejected.
- R9: `req_valid` while `busy` is 1 has no effect on the running chain. This holds even when it falls in the same cycle as an `op_done`, including the final one.
- R10: An aligned request with `req_len`=0 starts no unit. It leaves `state` at 0 and pulses `irq_done` in the next cycle, if enabled.
- R11: With `irq_en`=0 at the end of a request, `irq_done` stays 0, while the chain itself runs exactly as before.
- R12: `err_align` and `err_fail` hold their value until the next accepted request (idle and aligned, any length). Both flags clear in the cycle after that acceptance.
- R13: `op_done` while `state` is 0 has no effect, whatever `op_ok` says: no unit, no interrupt and no flag change.

Parameters: `ADDR_W` (24), `LEN_W` (24), `SECTOR_LG` (13), `DWORD_LG` (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_kind | input | 1 | 0 = erase range, 1 = program range |
| req_addr | input | ADDR_W | Start byte address of the range |
| req_len | input | LEN_W | Length of the range in bytes |
| req_ptr | input | ADDR_W | Source data pointer for program requests |
| irq_en | input | 1 | Completion interrupt enable |
| op_start | output | 1 | One-cycle start of a single unit |
| op_kind | output | 1 | Unit type: 0 = sector erase, 1 = double-word program |
| op_addr | output | ADDR_W | Flash address of the current unit |
| op_ptr | output | ADDR_W | Data pointer of the current program unit |
| op_done | input | 1 | One-cycle completion of the outstanding unit |
| op_ok | input | 1 | Result qualifier for op_done: 1 = success |
| busy | output | 1 | A chain is running |
| state | output | 2 | 0 idle, 1 writing, 2 erasing |
| err_align | output | 1 | Sticky: last request was rejected as misaligned |
| err_fail | output | 1 | Sticky: a unit reported failure |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
Two events can fall in the same cycle: a fresh request arrives just as the running chain receives a completion, possibly the one that ends it. To provoke this, the bench raises `req_valid` for a different range right after a chain starts. It holds that strobe through every completion cycle, the last one included, and drops it only once `busy` reads 0. The result is judged by two things. The count and addresses of the units issued must match the original request alone. After the strobe is released, no second chain may start.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Status code seen at the port; values are part of the interface.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITING = 2'd1,
        ST_ERASING = 2'd2
    } seq_state_e;

    typedef enum logic {
        OP_ERASE   = 1'b0,
        OP_PROGRAM = 1'b1
    } op_kind_e;

    // Outcome of looking at a request strobe; at most one bit is set.
    typedef struct packed {
        logic start;   // aligned, non-empty: begin a chain
        logic zero;    // aligned, empty: finish at once
        logic reject;  // misaligned: flag and drop
    } admit_t;

    function automatic seq_state_e state_for(input op_kind_e k);
        return (k == OP_PROGRAM) ? ST_WRITING : ST_ERASING;
    endfunction

endpackage

// File: rtl/fseq_admit.sv
module fseq_admit
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 24,
    parameter int SECTOR_LG = 13,
    parameter int DWORD_LG  = 3
) (
    input  logic              req_valid,
    input  logic              idle,
    input  op_kind_e          kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output admit_t            dec
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [ADDR_W-1:0] SEC_MASK = {{(ADDR_W-SECTOR_LG){1'b0}}, {SECTOR_LG{1'b1}}};
    localparam logic [ADDR_W-1:0] DW_MASK  = {{(ADDR_W-DWORD_LG){1'b0}}, {DWORD_LG{1'b1}}};

    logic [ADDR_W-1:0] mask;
    logic              misalign;
    logic              take;
    logic              empty;

    always_comb begin
        mask     = (kind == OP_PROGRAM) ? DW_MASK : SEC_MASK;
        misalign = |(addr & mask);
        take     = req_valid & idle;
        empty    = (len == '0);
        // alignment is judged before length
        dec.reject = take & misalign;
        dec.zero   = take & ~misalign & empty;
        dec.start  = take & ~misalign & ~empty;
    end

endmodule

// File: rtl/fseq_cursor.sv
module fseq_cursor
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 24,
    parameter int SECTOR_LG = 13,
    parameter int DWORD_LG  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  op_kind_e          kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [ADDR_W-1:0] ptr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_ptr,
    output op_kind_e          cur_kind,
    output logic              more
);
    timeunit 1ns;
    timeprecision 1ps;

    // One spare bit so that a range ending at the top of the space compares right.
    localparam int EW = ADDR_W + 1;
    localparam logic [EW-1:0]     STEP_SEC = EW'(1) << SECTOR_LG;
    localparam logic [EW-1:0]     STEP_DW  = EW'(1) << DWORD_LG;
    localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(1) << DWORD_LG;

    logic [EW-1:0]     cur_q, fin_q, nxt;
    logic [ADDR_W-1:0] ptr_q;
    op_kind_e          kind_q;

    always_comb begin
        nxt  = cur_q + ((kind_q == OP_PROGRAM) ? STEP_DW : STEP_SEC);
        more = (nxt < fin_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            fin_q  <= '0;
            ptr_q  <= '0;
            kind_q <= OP_ERASE;
        end else if (load) begin
            cur_q  <= {1'b0, addr_in};
            fin_q  <= {1'b0, addr_in} + EW'(len_in);
            ptr_q  <= ptr_in;
            kind_q <= kind_in;
        end else if (advance) begin
            cur_q <= nxt;
            if (kind_q == OP_PROGRAM) begin
                ptr_q <= ptr_q + PTR_STEP;
            end
        end
    end

    assign cur_addr = cur_q[ADDR_W-1:0];
    assign cur_ptr  = ptr_q;
    assign cur_kind = kind_q;

    // R2: a freshly loaded range always has at least one unit to run before its end.
    assert_load_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur_q < fin_q));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  admit_t     dec,
    input  op_kind_e   kind_in,
    input  logic       irq_en,
    input  logic       op_done,
    input  logic       op_ok,
    input  logic       more,
    output seq_state_e state,
    output logic       busy,
    output logic       load,
    output logic       advance,
    output logic       op_start,
    output logic       irq_done,
    output logic       err_align,
    output logic       err_fail
);
    timeunit 1ns;
    timeprecision 1ps;

    seq_state_e state_q;
    logic       op_start_q, irq_q, err_align_q, err_fail_q;

    assign busy    = (state_q != ST_IDLE);
    assign load    = dec.start;
    assign advance = busy & op_done & op_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_start_q  <= 1'b0;
            irq_q       <= 1'b0;
            err_align_q <= 1'b0;
            err_fail_q  <= 1'b0;
        end else begin
            op_start_q <= 1'b0;
            irq_q      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (dec.start) begin
                        state_q     <= state_for(kind_in);
                        op_start_q  <= 1'b1;
                        err_align_q <= 1'b0;
                        err_fail_q  <= 1'b0;
                    end else if (dec.zero) begin
                        irq_q       <= irq_en;
                        err_align_q <= 1'b0;
                        err_fail_q  <= 1'b0;
                    end else if (dec.reject) begin
                        err_align_q <= 1'b1;
                    end
                end
                default: begin
                    if (op_done) begin
                        if (!op_ok) begin
                            err_fail_q <= 1'b1;
                            state_q    <= ST_IDLE;
                            irq_q      <= irq_en;
                        end else if (more) begin
                            op_start_q <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                            irq_q   <= irq_en;
                        end
                    end
                end
            endcase
        end
    end

    assign state     = state_q;
    assign op_start  = op_start_q;
    assign irq_done  = irq_q;
    assign err_align = err_align_q;
    assign err_fail  = err_fail_q;

    assert_start_in_chain_R4: assert property (@(posedge clk) disable iff (rst)
        op_start |-> busy);
    assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);
    assert_last_unit_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && op_done && op_ok && !more) |=> (state == ST_IDLE && !op_start));
    assert_fail_stops_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && op_done && !op_ok) |=> (state == ST_IDLE && err_fail && !op_start));
    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        dec.reject |=> (state == ST_IDLE && err_align && !op_start && !irq_done));
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> $past(irq_en));
    assert_idle_done_inert_R13: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_done && !dec.start && !dec.zero && !dec.reject) |=>
            (!op_start && !irq_done && $stable(err_fail) && $stable(err_align)));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 24,
    parameter int SECTOR_LG = 13,
    parameter int DWORD_LG  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_ptr,
    input  logic              irq_en,
    output logic              op_start,
    output logic              op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [ADDR_W-1:0] op_ptr,
    input  logic              op_done,
    input  logic              op_ok,
    output logic              busy,
    output logic [1:0]        state,
    output logic              err_align,
    output logic              err_fail,
    output logic              irq_done
);
    timeunit 1ns;
    timeprecision 1ps;

    op_kind_e   kind_in, cur_kind;
    admit_t     dec;
    seq_state_e st;
    logic       load, advance, more, busy_w;

    assign kind_in = op_kind_e'(req_kind);

    fseq_admit #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECTOR_LG(SECTOR_LG), .DWORD_LG(DWORD_LG)
    ) u_admit (
        .req_valid(req_valid),
        .idle     (!busy_w),
        .kind     (kind_in),
        .addr     (req_addr),
        .len      (req_len),
        .dec      (dec)
    );

    fseq_cursor #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECTOR_LG(SECTOR_LG), .DWORD_LG(DWORD_LG)
    ) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .kind_in (kind_in),
        .addr_in (req_addr),
        .len_in  (req_len),
        .ptr_in  (req_ptr),
        .cur_addr(op_addr),
        .cur_ptr (op_ptr),
        .cur_kind(cur_kind),
        .more    (more)
    );

    fseq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .kind_in  (kind_in),
        .irq_en   (irq_en),
        .op_done  (op_done),
        .op_ok    (op_ok),
        .more     (more),
        .state    (st),
        .busy     (busy_w),
        .load     (load),
        .advance  (advance),
        .op_start (op_start),
        .irq_done (irq_done),
        .err_align(err_align),
        .err_fail (err_fail)
    );

    assign op_kind = cur_kind;
    assign busy    = busy_w;
    assign state   = st;

    // R2 / R3: every issued unit sits on its own unit boundary.
    assert_unit_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        op_start |-> (op_kind ? (op_addr[DWORD_LG-1:0] == '0)
                              : (op_addr[SECTOR_LG-1:0] == '0)));
    // R5: the status code agrees with the kind held by the cursor.
    assert_state_kind_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (state == (op_kind ? 2'd1 : 2'd2)));
    // R9: a strobe during a chain, with no completion, moves nothing.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && !op_done) |=> ($stable(op_addr) && $stable(state) && !op_start));

endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW  = 24;
    localparam int LAT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_kind = 1'b0, irq_en = 1'b1;
    logic [AW-1:0] req_addr = '0, req_ptr = '0;
    logic [AW-1:0] req_len = '0;
    logic          op_start, op_kind, busy, err_align, err_fail, irq_done;
    logic [AW-1:0] op_addr, op_ptr;
    logic [1:0]    state;
    logic          resp_done = 1'b0, resp_ok = 1'b1, poke_done = 1'b0, poke_bad = 1'b0;
    logic          op_done, op_ok;

    assign op_done = resp_done | poke_done;
    assign op_ok   = resp_ok & ~poke_bad;

    always #2 clk = ~clk;

    flash_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_ptr(req_ptr), .irq_en(irq_en),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_ptr(op_ptr),
        .op_done(op_done), .op_ok(op_ok), .busy(busy), .state(state),
        .err_align(err_align), .err_fail(err_fail), .irq_done(irq_done)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Fixed-latency responder plus bookkeeping of issued units.
    int            lat_cnt = 0, ops_seen = 0, ops_wrong = 0, irq_seen = 0, fail_at = -1;
    logic [AW-1:0] exp_addr = '0, exp_ptr = '0;
    logic [AW-1:0] exp_unit = '0;
    logic          exp_kind = 1'b0;

    always @(negedge clk) begin
        resp_done = 1'b0;
        resp_ok   = 1'b1;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                resp_done = 1'b1;
                resp_ok   = ((ops_seen - 1) != fail_at);
            end
        end
        if (op_start) begin
            if (op_addr !== exp_addr || op_kind !== exp_kind || (exp_kind && op_ptr !== exp_ptr))
                ops_wrong++;
            exp_addr = exp_addr + exp_unit;
            exp_ptr  = exp_ptr + 24'd8;
            ops_seen++;
            lat_cnt = LAT;
        end
        if (irq_done) irq_seen++;
    end

    logic [1:0] st_after;
    logic       busy_after;

    task automatic arm(input logic k, input logic [AW-1:0] a, input logic [AW-1:0] p);
        exp_kind = k;
        exp_addr = a;
        exp_ptr  = p;
        exp_unit = k ? 24'd8 : 24'h2000;
        ops_seen = 0; ops_wrong = 0; irq_seen = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input logic k, input logic [AW-1:0] a, input logic [AW-1:0] l,
                       input logic [AW-1:0] p);
        arm(k, a, p);
        @(negedge clk);
        req_kind = k; req_addr = a; req_len = l; req_ptr = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        st_after   = state;
        busy_after = busy;
        wait_idle();
    endtask

    typedef struct packed {
        logic          kind;
        logic [AW-1:0] addr;
        logic [AW-1:0] len;
        logic [AW-1:0] ptr;
        int            ops;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h002000, 24'h002000, 24'h000000, 1},
        '{1'b0, 24'h004000, 24'h006000, 24'h000000, 3},
        '{1'b0, 24'h006000, 24'h002001, 24'h000000, 2},
        '{1'b1, 24'h000100, 24'h000028, 24'h100000, 5},
        '{1'b1, 24'h000008, 24'h000008, 24'h100040, 1},
        '{1'b1, 24'h0FFFF0, 24'h00000C, 24'h100080, 2},
        '{1'b0, 24'hFFE000, 24'h002000, 24'h000000, 1}
    };

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values, while reset is held and in the cycle after it falls
        chk("R1", "state in reset", state, 0);
        chk("R1", "busy in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "state", state, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "op_start", op_start, 0);
        chk("R1", "irq_done", irq_done, 0);
        chk("R1", "err_align", err_align, 0);
        chk("R1", "err_fail", err_fail, 0);

        // R2 / R3 / R5 / R6: table of ranges
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].kind, VECS[i].addr, VECS[i].len, VECS[i].ptr);
            chk(VECS[i].kind ? "R3" : "R2", "unit count", ops_seen, VECS[i].ops);
            chk(VECS[i].kind ? "R3" : "R2", "wrong units", ops_wrong, 0);
            chk("R5", "state while running", st_after, VECS[i].kind ? 1 : 2);
            chk("R5", "busy while running", busy_after, 1);
            chk("R6", "irq pulses", irq_seen, 1);
            chk("R6", "state after", state, 0);
        end

        // R8: misaligned erase
        run(1'b0, 24'h001000, 24'h002000, 24'h0);
        chk("R8", "erase reject units", ops_seen, 0);
        chk("R8", "erase reject flag", err_align, 1);
        chk("R8", "erase reject irq", irq_seen, 0);
        chk("R8", "erase reject state", st_after, 0);
        // R8: misaligned zero-length program is still rejected
        run(1'b1, 24'h000004, 24'h000000, 24'h0);
        chk("R8", "prog reject flag", err_align, 1);
        chk("R8", "prog reject irq", irq_seen, 0);

        // R12: an accepted request clears the alignment flag
        run(1'b1, 24'h000010, 24'h000008, 24'h000200);
        chk("R12", "align flag cleared", err_align, 0);
        chk("R3", "single unit", ops_seen, 1);

        // R10: zero-length aligned request
        run(1'b0, 24'h002000, 24'h000000, 24'h0);
        chk("R10", "no units", ops_seen, 0);
        chk("R10", "irq pulse", irq_seen, 1);
        chk("R10", "state", st_after, 0);

        // R7: second unit of four fails
        fail_at = 1;
        run(1'b0, 24'h010000, 24'h008000, 24'h0);
        fail_at = -1;
        chk("R7", "units before stop", ops_seen, 2);
        chk("R7", "fail flag", err_fail, 1);
        chk("R7", "irq pulse", irq_seen, 1);
        chk("R7", "state", state, 0);
        repeat (10) @(negedge clk);
        chk("R12", "fail flag sticky", err_fail, 1);
        run(1'b0, 24'h004000, 24'h000000, 24'h0);
        chk("R12", "fail flag cleared", err_fail, 0);

        // R11: interrupt disabled
        irq_en = 1'b0;
        run(1'b1, 24'h000200, 24'h000018, 24'h000300);
        chk("R11", "units", ops_seen, 3);
        chk("R11", "wrong units", ops_wrong, 0);
        chk("R11", "irq pulses", irq_seen, 0);
        irq_en = 1'b1;

        // R9: a foreign request held through every completion, the last included
        arm(1'b0, 24'h020000, 24'h0);
        @(negedge clk);
        req_kind = 1'b0; req_addr = 24'h020000; req_len = 24'h006000; req_valid = 1'b1;
        @(negedge clk);
        req_kind = 1'b1; req_addr = 24'h040000; req_len = 24'h000008; req_ptr = 24'h000500;
        while (busy) @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9", "units", ops_seen, 3);
        chk("R9", "wrong units", ops_wrong, 0);
        chk("R9", "irq pulses", irq_seen, 1);
        chk("R9", "busy after", busy, 0);

        // R13: completion strobes while idle, with and without success
        arm(1'b0, 24'h0, 24'h0);
        @(negedge clk);
        poke_done = 1'b1;
        @(negedge clk);
        poke_bad = 1'b1;
        @(negedge clk);
        poke_done = 1'b0; poke_bad = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13", "units", ops_seen, 0);
        chk("R13", "irq", irq_seen, 0);
        chk("R13", "fail flag", err_fail, 0);
        chk("R13", "state", state, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule